// File: doc/BRIEF.md
# Two-Wire Bus Slave Front-End with Strapped Address

This block is the protocol front-end of a two-wire serial bus slave. It oversamples the bus clock and data lines with a faster system clock and finds the bus conditions that open and close a transfer. It shifts in the first byte, which holds the seven-bit address and the direction bit, and acknowledges that byte only when the address is its own. Four address bits are fixed. The three bits at even positions come from strap pins.

Once it has been selected, the block moves bytes between the bus and a simple parallel port to a register file. Each byte the master writes appears on a data output together with a one-cycle valid strobe. For reads, the block raises a one-cycle request, takes the byte offered on its read-data input and sends it out most significant bit first. The data line is only ever pulled low through an output enable, because the bus is open drain.

Top module: `i2cs_front`

## Requirements
- R1: The slave address is, from the most significant bit down, 1, 0, strap[2], 0, strap[1], 0, strap[0]. The block pulls the data line low on the ninth clock of the first byte only when the upper seven bits of that byte equal this address.
- R2: Bit 0 of the address byte selects the direction and is reported on `dir_rd_o`: 0 means the master writes and 1 means the master reads.
- R3: A START (data falling while the clock is high) seen from idle, from a selected transfer or from the passive state begins a new address byte. This includes a repeated START during a selected transfer.
- R4: While the address byte and its acknowledge slot are in progress, START and STOP patterns are ignored and the bits keep accumulating.
- R5: During a write, the block acknowledges every data byte by pulling the data line low on that byte's ninth clock. It releases the line after the ninth clock's falling edge.
- R6: Write bytes are assembled most significant bit first. Each byte is presented on `wr_data_o` with `wr_valid_o` high for exactly one system clock after its eighth bit.
- R7: In a read, `rd_req_o` pulses for one cycle after the address acknowledge and after each acknowledged byte. The byte on `rd_data_i` is sent most significant bit first, starting with the next data clock.
- R8: If the master does not acknowledge a read byte, the block stops driving, sends no further bits and raises no further requests.
- R9: On an address mismatch the block never drives the data line and produces no write strobes until the next START or STOP.
- R10: The data line is driven only as an open-drain low through `sda_oe_o`. The enable is low after reset, and it only rises while the bus clock is low.
- R11: A STOP seen after selection returns the block to idle, and `sel_o` goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the bus clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as sensed |
| sda_i | input | 1 | Bus data line as sensed |
| strap_i | input | 3 | Strap pins for the even address bits |
| sda_oe_o | output | 1 | When high, pull the data line low |
| sel_o | output | 1 | Block is selected in a data phase |
| dir_rd_o | output | 1 | Direction of the current transfer (1 = read) |
| wr_data_o | output | 8 | Last byte written by the master |
| wr_valid_o | output | 1 | One-cycle strobe for `wr_data_o` |
| rd_req_o | output | 1 | One-cycle request for the next read byte |
| rd_data_i | input | 8 | Byte to send, valid in the cycle of `rd_req_o` |

## Verification
The hardest case to reach is a STOP or START pattern that falls inside the address byte. A stop sequence always brings a rising clock edge with the data line low, so it carries a data bit of its own. The bench chooses the bits around it so that the address still matches once the bit the pattern supplies is counted. An acknowledge on that byte therefore shows the condition was ignored, and a missing acknowledge shows it was wrongly honoured. A repeated START issued right after a selected write byte then shows that the same pattern is honoured once selection has happened.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 7;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_WRITE,
    PH_READ,
    PH_PASSIVE
  } phase_t;
endpackage

// File: rtl/i2cs_sync.sv
module i2cs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic rst_sn,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] rst_pipe;
  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic              scl_q;
  logic              sda_q;
  logic              scl_s;

  // reset: asserted at once, released through the chain
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[STAGES-2:0], 1'b1};
  end
  assign rst_sn = rst_pipe[STAGES-1];

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_q    <= scl_s;
      sda_q    <= sda_s;
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2cs_ctrl.sv
module i2cs_ctrl
  import i2cs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic              sda_oe_o,
  output logic              sel_o,
  output logic              dir_rd_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic              wr_valid_o,
  output logic              rd_req_o
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] ACK_SLOT = CNT_W'(BYTE_W);

  phase_t            phase, phase_n;
  logic [CNT_W-1:0]  cnt, cnt_n;
  logic [BYTE_W-1:0] shreg, sh_n;
  logic [BYTE_W-1:0] txreg, tx_n;
  logic [BYTE_W-1:0] tx_shifted;
  logic [BYTE_W-1:0] wd_n;
  logic              oe_n, dir_n, wv_n, rq_n;

  assign tx_shifted = txreg << cnt;

  always_comb begin
    phase_n = phase;
    cnt_n   = cnt;
    sh_n    = shreg;
    tx_n    = rd_req_o ? rd_data_i : txreg;
    oe_n    = sda_oe_o;
    dir_n   = dir_rd_o;
    wd_n    = wr_data_o;
    wv_n    = 1'b0;
    rq_n    = 1'b0;
    if (start_det && phase != PH_ADDR) begin
      phase_n = PH_ADDR;
      cnt_n   = '0;
      oe_n    = 1'b0;
    end else if (stop_det && phase != PH_ADDR) begin
      phase_n = PH_IDLE;
      cnt_n   = '0;
      oe_n    = 1'b0;
    end else if (scl_rise) begin
      case (phase)
        PH_ADDR: begin
          if (cnt != ACK_SLOT) begin
            sh_n  = {shreg[BYTE_W-2:0], sda_s};
            cnt_n = cnt + 1'b1;
            if (cnt == LAST_BIT) begin
              if (sh_n[BYTE_W-1:1] == own_addr) dir_n = sda_s;
              else                              phase_n = PH_PASSIVE;
            end
          end else begin
            cnt_n   = '0;
            phase_n = dir_rd_o ? PH_READ : PH_WRITE;
            rq_n    = dir_rd_o;
          end
        end
        PH_WRITE: begin
          if (cnt != ACK_SLOT) begin
            sh_n  = {shreg[BYTE_W-2:0], sda_s};
            cnt_n = cnt + 1'b1;
            if (cnt == LAST_BIT) begin
              wd_n = sh_n;
              wv_n = 1'b1;
            end
          end else begin
            cnt_n = '0;
          end
        end
        PH_READ: begin
          if (cnt != ACK_SLOT) begin
            cnt_n = cnt + 1'b1;
          end else if (!sda_s) begin
            cnt_n = '0;
            rq_n  = 1'b1;
          end else begin
            phase_n = PH_PASSIVE;
          end
        end
        default: ;
      endcase
    end else if (scl_fall) begin
      case (phase)
        PH_ADDR, PH_WRITE: oe_n = (cnt == ACK_SLOT);
        PH_READ:           oe_n = (cnt != ACK_SLOT) && !tx_shifted[BYTE_W-1];
        default:           oe_n = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase      <= PH_IDLE;
      cnt        <= '0;
      shreg      <= '0;
      txreg      <= '0;
      sda_oe_o   <= 1'b0;
      dir_rd_o   <= 1'b0;
      wr_data_o  <= '0;
      wr_valid_o <= 1'b0;
      rd_req_o   <= 1'b0;
    end else begin
      phase      <= phase_n;
      cnt        <= cnt_n;
      shreg      <= sh_n;
      txreg      <= tx_n;
      sda_oe_o   <= oe_n;
      dir_rd_o   <= dir_n;
      wr_data_o  <= wd_n;
      wr_valid_o <= wv_n;
      rd_req_o   <= rq_n;
    end
  end

  assign sel_o = (phase == PH_WRITE) || (phase == PH_READ);
endmodule

// File: rtl/i2cs_front.sv
module i2cs_front
  import i2cs_pkg::*;
#(
  parameter int              SYNC_STAGES = 2,
  parameter int              STRAP_W     = 3,
  parameter logic [ADDR_W-1:0] ADDR_BASE = 7'b1000000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  input  logic [STRAP_W-1:0] strap_i,
  output logic               sda_oe_o,
  output logic               sel_o,
  output logic               dir_rd_o,
  output logic [BYTE_W-1:0]  wr_data_o,
  output logic               wr_valid_o,
  output logic               rd_req_o,
  input  logic [BYTE_W-1:0]  rd_data_i
);
  logic              rst_sn, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [ADDR_W-1:0] own_addr;

  // strap pins land on the even address positions
  always_comb begin
    own_addr = ADDR_BASE;
    for (int i = 0; i < STRAP_W; i++) own_addr[2*i] = strap_i[i];
  end

  i2cs_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .rst_sn    (rst_sn),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2cs_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_sn),
    .sda_s      (sda_s),
    .scl_rise   (scl_rise),
    .scl_fall   (scl_fall),
    .start_det  (start_det),
    .stop_det   (stop_det),
    .own_addr   (own_addr),
    .rd_data_i  (rd_data_i),
    .sda_oe_o   (sda_oe_o),
    .sel_o      (sel_o),
    .dir_rd_o   (dir_rd_o),
    .wr_data_o  (wr_data_o),
    .wr_valid_o (wr_valid_o),
    .rd_req_o   (rd_req_o)
  );
endmodule

// File: rtl/i2cs_front_chk.sv
module i2cs_front_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_i,
  input logic sda_oe_o,
  input logic sel_o,
  input logic dir_rd_o,
  input logic wr_valid_o,
  input logic rd_req_o
);
  // R6: write strobe lasts one cycle
  p_wr_strobe_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o |=> !wr_valid_o);

  // R2: write strobes only in write direction
  p_wr_strobe_dir_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o |-> (sel_o && !dir_rd_o));

  // R7: read request lasts one cycle and only in read direction
  p_rd_req_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_o |=> !rd_req_o);

  p_rd_req_dir_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_o |-> (sel_o && dir_rd_o));

  // R1: selection begins while the address acknowledge is driven
  p_sel_with_ack_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sel_o) |-> sda_oe_o);

  // R10: driver turns on only while the bus clock is low
  p_oe_rise_scl_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe_o) |-> !scl_i);
endmodule

bind i2cs_front i2cs_front_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .scl_i      (scl_i),
  .sda_oe_o   (sda_oe_o),
  .sel_o      (sel_o),
  .dir_rd_o   (dir_rd_o),
  .wr_valid_o (wr_valid_o),
  .rd_req_o   (rd_req_o)
);

// File: tb/i2cs_front_tb.sv
module i2cs_front_tb;
  localparam int Q = 5;

  logic       clk;
  logic       rst_n;
  logic       scl_m, sda_m;
  logic [2:0] strap;
  logic       sda_oe, sel, dir_rd, wr_valid, rd_req;
  logic [7:0] wr_data, rd_data;
  logic       sda_line;

  int checks, failures, cycles;
  int wr_cnt, rd_cnt, oe_seen;
  logic [7:0] wr_last;
  logic [7:0] rd_ptr;
  bit   watch_oe, done;

  assign sda_line = sda_m & ~sda_oe;

  function automatic logic [7:0] rom(input logic [7:0] p);
    return 8'h5A ^ (p * 8'h37);
  endfunction

  assign rd_data = rom(rd_ptr);

  i2cs_front u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_m),
    .sda_i      (sda_line),
    .strap_i    (strap),
    .sda_oe_o   (sda_oe),
    .sel_o      (sel),
    .dir_rd_o   (dir_rd),
    .wr_data_o  (wr_data),
    .wr_valid_o (wr_valid),
    .rd_req_o   (rd_req),
    .rd_data_i  (rd_data)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (wr_valid) begin wr_cnt <= wr_cnt + 1; wr_last <= wr_data; end
    if (rd_req) begin rd_cnt <= rd_cnt + 1; rd_ptr <= rd_ptr + 8'd1; end
    if (watch_oe && sda_oe) oe_seen <= oe_seen + 1;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      failures = failures + 1;
      $display("FAIL watchdog: actual=%0d cycles expected=<150000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; scl_m = 1'b1; wq(2*Q);
    sda_m = 1'b0; wq(2*Q);
  endtask

  task automatic bus_rstart();
    scl_m = 1'b0; wq(Q); sda_m = 1'b1; wq(Q);
    scl_m = 1'b1; wq(Q); sda_m = 1'b0; wq(Q);
  endtask

  task automatic bus_stop();
    scl_m = 1'b0; wq(Q); sda_m = 1'b0; wq(Q);
    scl_m = 1'b1; wq(Q); sda_m = 1'b1; wq(2*Q);
  endtask

  task automatic put_bit(input logic b);
    scl_m = 1'b0; wq(Q); sda_m = b; wq(Q);
    scl_m = 1'b1; wq(2*Q);
  endtask

  task automatic get_bit(output logic b);
    scl_m = 1'b0; wq(Q); sda_m = 1'b1; wq(Q);
    scl_m = 1'b1; wq(Q); b = sda_line; wq(Q);
  endtask

  task automatic put_byte(input logic [7:0] v, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(b);
    ack = ~b;
  endtask

  task automatic get_byte(input logic ack, output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin get_bit(b); v[i] = b; end
    put_bit(~ack);
  endtask

  task automatic t_reset();
    chk(sda_oe == 1'b0, "R10 oe after reset", sda_oe, 0);
    chk(sel == 1'b0, "R11 sel after reset", sel, 0);
    chk(wr_valid == 1'b0 && rd_req == 1'b0, "R6 strobes after reset", {wr_valid, rd_req}, 0);
  endtask

  task automatic t_write();
    logic ack; int w0;
    strap = 3'b101; w0 = wr_cnt;
    bus_start();
    put_byte(8'hA2, ack);
    chk(ack, "R1 ack strap 101 addr 0x51", ack, 1);
    chk(sel && !dir_rd, "R2 write direction", {sel, dir_rd}, 2);
    put_byte(8'h3C, ack);
    chk(ack, "R5 ack data byte 1", ack, 1);
    chk(wr_last == 8'h3C && wr_cnt == w0 + 1, "R6 first write byte", wr_last, 8'h3C);
    put_byte(8'hF0, ack);
    chk(ack, "R5 ack data byte 2", ack, 1);
    chk(wr_last == 8'hF0 && wr_cnt == w0 + 2, "R6 second write byte", wr_last, 8'hF0);
    bus_stop();
    chk(!sel && !sda_oe, "R11 stop ends transfer", {sel, sda_oe}, 0);
  endtask

  task automatic t_mismatch();
    logic ack; int w0;
    strap = 3'b101; w0 = wr_cnt;
    bus_start();
    oe_seen = 0; watch_oe = 1'b1;
    put_byte(8'hA6, ack);
    chk(!ack, "R1 no ack for 0x53", ack, 0);
    put_byte(8'h55, ack);
    watch_oe = 1'b0;
    chk(!ack && oe_seen == 0, "R9 line never driven", oe_seen, 0);
    chk(wr_cnt == w0 && !sel, "R9 no write strobe", wr_cnt - w0, 0);
    bus_stop();
  endtask

  task automatic t_read();
    logic ack, b; logic [7:0] v; logic [7:0] p0; int r0;
    strap = 3'b101; r0 = rd_cnt; p0 = rd_ptr;
    bus_start();
    put_byte(8'hA3, ack);
    chk(ack && sel && dir_rd, "R2 read direction acked", {ack, sel, dir_rd}, 7);
    get_byte(1'b1, v);
    chk(v == rom(p0), "R7 read byte 0", v, rom(p0));
    get_byte(1'b1, v);
    chk(v == rom(p0 + 8'd1), "R7 read byte 1", v, rom(p0 + 8'd1));
    get_byte(1'b0, v);
    chk(v == rom(p0 + 8'd2), "R7 read byte 2", v, rom(p0 + 8'd2));
    oe_seen = 0; watch_oe = 1'b1;
    for (int i = 0; i < 8; i++) begin get_bit(b); v[7-i] = b; end
    watch_oe = 1'b0;
    chk(v == 8'hFF && oe_seen == 0, "R8 released after nack", v, 8'hFF);
    chk(rd_cnt == r0 + 3, "R8 request count", rd_cnt - r0, 3);
    bus_stop();
  endtask

  task automatic t_ignore_cond();
    logic ack; logic [7:0] v; int w0;
    strap = 3'b101; w0 = wr_cnt;
    bus_start();
    put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
    bus_stop();                                  // supplies bit 4 = 0, must be ignored
    put_bit(1'b0); put_bit(1'b0); put_bit(1'b1); put_bit(1'b0);
    get_bit(v[0]);
    chk(v[0] == 1'b0 && sel, "R4 stop in address ignored", v[0], 0);
    put_byte(8'h81, ack);
    chk(ack && wr_last == 8'h81 && wr_cnt == w0 + 1, "R4 write after ignored stop", wr_last, 8'h81);
    bus_rstart();
    put_byte(8'hA3, ack);
    chk(ack && sel && dir_rd, "R3 repeated start honoured", {ack, sel, dir_rd}, 7);
    get_byte(1'b0, v);
    bus_stop();
    chk(!sel, "R11 idle after stop", sel, 0);
  endtask

  task automatic t_strap2();
    logic ack;
    strap = 3'b010;
    bus_start();
    put_byte(8'hA2, ack);
    chk(!ack, "R1 old address rejected with strap 010", ack, 0);
    bus_stop();
    bus_start();
    put_byte(8'h88, ack);
    chk(ack && sel, "R1 ack strap 010 addr 0x44", ack, 1);
    put_byte(8'hC3, ack);
    chk(ack && wr_last == 8'hC3, "R6 write with strap 010", wr_last, 8'hC3);
    bus_stop();
  endtask

  initial begin
    checks = 0; failures = 0; cycles = 0;
    wr_cnt = 0; rd_cnt = 0; oe_seen = 0; wr_last = '0; rd_ptr = '0;
    watch_oe = 1'b0; done = 1'b0;
    scl_m = 1'b1; sda_m = 1'b1; strap = 3'b101;
    rst_n = 1'b0;
    wq(4);
    rst_n = 1'b1;
    wq(6);
    t_reset();
    t_write();
    t_mismatch();
    t_read();
    t_ignore_cond();
    t_strap2();
    wq(10);
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule